// File: doc/BRIEF.md
# Dual-Processor Mailbox Register Bank

This block lets two processors that share one clock pass 32-bit words to each other through a set of one-word channels. Each side has its own simple register port. On that port it sees four transmit words, four receive words, a status word and a control word. A word that one side writes into its transmit slot n shows up in the other side's receive slot n. The sender keeps a per-channel "empty" view of the slot and the receiver keeps a per-channel "full" view. A read of the receive slot hands the slot back to the sender.

Each side raises one interrupt line. The line is the OR of its enabled per-channel sources: "my transmit slot is free" and "my receive slot holds a word", each with its own enable bit. The A side can also clear the whole unit, both sides at once, by writing a self-clearing bit in its control word.

Accesses are single-cycle. Read data and the error flag are combinational from the request in the same cycle. State changes at the following rising edge. Word addresses for CH=4 channels:

- 0 to 3: transmit
- 4 to 7: receive
- 8: status
- 9: control

Top module: `dual_mailbox`

## Requirements
- R1: After reset, both status words read 0x00F00000 (transmit-empty bits 23:20 all 1, receive-full bits 27:24 all 0), both control words read 0, both interrupt lines are low and all receive words read 0.
- R2: An accepted write to transmit word n (address n) on one side can be read from the peer's receive word n (address 4+n) from the next cycle on, and it sets the peer's receive-full bit 24+n.
- R3: A read of receive word n clears that side's receive-full bit 24+n and sets the peer's transmit-empty bit 20+n from the next cycle on.
- R4: An accepted write to transmit word n clears the writer's transmit-empty bit 20+n. A write to transmit word n while that bit is 0 is dropped, answered with the error flag, and leaves the peer's receive word unchanged.
- R5: A write to any receive word raises the error flag. Any access to an address above the control word (address 10 and up) also raises the error flag, and a read there returns 0.
- R6: A read of a transmit word returns 0 with no error.
- R7: The control word holds transmit-interrupt enables at bits 23:20 and receive-interrupt enables at bits 27:24. A side's interrupt line is high exactly when some channel n has (empty n and transmit enable n) or (full n and receive enable n).
- R8: An A-side write to control with bit 0 set returns all state of both sides, enables included, to the R1 values at the next cycle. Control bit 0 always reads 0. On the B side, bit 0 has no effect.
- R9: A write to the status word (address 8) is ignored and gives no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_req | input | 1 | A-side access request, one cycle per access |
| a_we | input | 1 | A-side write (1) or read (0) |
| a_addr | input | 4 | A-side word address |
| a_wdata | input | 32 | A-side write data |
| a_rdata | output | 32 | A-side read data, same cycle as the request |
| a_err | output | 1 | A-side error response, same cycle as the request |
| a_irq | output | 1 | A-side interrupt line |
| b_req | input | 1 | B-side access request |
| b_we | input | 1 | B-side write (1) or read (0) |
| b_addr | input | 4 | B-side word address |
| b_wdata | input | 32 | B-side write data |
| b_rdata | output | 32 | B-side read data, same cycle as the request |
| b_err | output | 1 | B-side error response |
| b_irq | output | 1 | B-side interrupt line |

## Verification
The only stored state is one occupancy bit and one data word per channel and direction, plus the enable bits. A wrong occupancy bit therefore shows on the very next status read of either side. It also shows at once on an interrupt line whose enable is set, and as an unexpected error on the next write to that transmit slot. A corrupted data word only shows when the peer reads that receive slot. The bench therefore reads back every transferred word and reads status on both sides after each handoff. A unit clear that misses a register shows at the first read of the status, control or receive words after the clear.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;

  // Status and control field positions; software on both sides decodes these.
  localparam int unsigned EMPTY_LSB = 20;
  localparam int unsigned FULL_LSB  = 24;
  localparam int unsigned CLR_BIT   = 0;

  typedef enum logic [2:0] {
    ACC_TX,
    ACC_RX,
    ACC_STAT,
    ACC_CTRL,
    ACC_NONE
  } acc_e;

  // Word map: [0,ch) transmit, [ch,2ch) receive, 2ch status, 2ch+1 control.
  function automatic acc_e mbox_decode(input int unsigned a, input int unsigned ch);
    if (a < ch)               return ACC_TX;
    else if (a < 2 * ch)      return ACC_RX;
    else if (a == 2 * ch)     return ACC_STAT;
    else if (a == 2 * ch + 1) return ACC_CTRL;
    else                      return ACC_NONE;
  endfunction

endpackage

// File: rtl/mbox_rst_sync.sv
`timescale 1ns/1ps
module mbox_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
`timescale 1ns/1ps
module mbox_channel #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data,
  output logic          full
);
  logic [DW-1:0] data_q, data_d;
  logic          full_q, full_d;
  logic          en;

  // Sender only writes when the slot is free, so wr and a draining rd never
  // fight over a held word; wr wins so fresh data is never lost.
  always_comb begin
    data_d = data_q;
    full_d = full_q;
    en     = clr | wr | rd;
    if (clr) begin
      data_d = '0;
      full_d = 1'b0;
    end else if (wr) begin
      data_d = wdata;
      full_d = 1'b1;
    end else if (rd) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (en) begin
      data_q <= data_d;
      full_q <= full_d;
    end
  end

  assign data = data_q;
  assign full = full_q;
endmodule

// File: rtl/mbox_port.sv
`timescale 1ns/1ps
module mbox_port
  import mbox_pkg::*;
#(
  parameter int unsigned CH      = 4,
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 4,
  parameter bit          HAS_CLR = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 req,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic                 err,
  output logic                 irq,
  input  logic [CH-1:0]        tx_empty,
  input  logic [CH-1:0]        rx_full,
  input  logic [CH-1:0][DW-1:0] rx_data,
  output logic [CH-1:0]        tx_wr,
  output logic [CH-1:0]        rx_rd,
  output logic                 clr_req
);
  acc_e          acc;
  int unsigned   ch_i;
  logic          sel_empty;
  logic [CH-1:0] tie_q, tie_d;
  logic [CH-1:0] rie_q, rie_d;
  logic          ctrl_wr;
  logic          ctrl_en;

  always_comb begin
    acc  = mbox_decode(int'(addr), CH);
    ch_i = (acc == ACC_RX) ? int'(addr) - CH : int'(addr);
  end

  // Channel strobes and the selected empty bit
  always_comb begin
    tx_wr     = '0;
    rx_rd     = '0;
    sel_empty = 1'b0;
    for (int n = 0; n < CH; n++) begin
      if (ch_i == n) begin
        sel_empty = tx_empty[n];
        tx_wr[n]  = req && we && (acc == ACC_TX) && tx_empty[n];
        rx_rd[n]  = req && !we && (acc == ACC_RX);
      end
    end
  end

  // Read mux and error response
  always_comb begin
    rdata = '0;
    err   = 1'b0;
    unique case (acc)
      ACC_TX:   err = req && we && !sel_empty;
      ACC_RX: begin
        err = req && we;
        for (int n = 0; n < CH; n++) begin
          if (ch_i == n) rdata = rx_data[n];
        end
      end
      ACC_STAT: begin
        rdata[EMPTY_LSB +: CH] = tx_empty;
        rdata[FULL_LSB  +: CH] = rx_full;
      end
      ACC_CTRL: begin
        rdata[EMPTY_LSB +: CH] = tie_q;
        rdata[FULL_LSB  +: CH] = rie_q;
      end
      default:  err = req;
    endcase
  end

  // Interrupt enables: next state
  always_comb begin
    ctrl_wr = req && we && (acc == ACC_CTRL);
    ctrl_en = clr | ctrl_wr;
    tie_d   = tie_q;
    rie_d   = rie_q;
    if (clr) begin
      tie_d = '0;
      rie_d = '0;
    end else if (ctrl_wr) begin
      tie_d = wdata[EMPTY_LSB +: CH];
      rie_d = wdata[FULL_LSB  +: CH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tie_q <= '0;
      rie_q <= '0;
    end else if (ctrl_en) begin
      tie_q <= tie_d;
      rie_q <= rie_d;
    end
  end

  generate
    if (HAS_CLR) begin : g_clr
      assign clr_req = ctrl_wr && wdata[CLR_BIT];
    end else begin : g_noclr
      assign clr_req = 1'b0;
    end
  endgenerate

  assign irq = (|(tie_q & tx_empty)) | (|(rie_q & rx_full));
endmodule

// File: rtl/dual_mailbox.sv
`timescale 1ns/1ps
module dual_mailbox #(
  parameter int unsigned CH = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_req,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_err,
  output logic          a_irq,
  input  logic          b_req,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_err,
  output logic          b_irq
);
  logic                 rst_s;
  logic                 unit_clr;
  logic                 a_clr_req, b_clr_req;
  logic [CH-1:0]        ab_occ, ba_occ;
  logic [CH-1:0][DW-1:0] ab_data, ba_data;
  logic [CH-1:0]        a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;

  mbox_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  assign unit_clr = a_clr_req | b_clr_req;

  generate
    for (genvar n = 0; n < CH; n++) begin : g_ch
      mbox_channel #(.DW(DW)) u_ab (
        .clk   (clk),
        .rst_n (rst_s),
        .clr   (unit_clr),
        .wr    (a_tx_wr[n]),
        .rd    (b_rx_rd[n]),
        .wdata (a_wdata),
        .data  (ab_data[n]),
        .full  (ab_occ[n])
      );
      mbox_channel #(.DW(DW)) u_ba (
        .clk   (clk),
        .rst_n (rst_s),
        .clr   (unit_clr),
        .wr    (b_tx_wr[n]),
        .rd    (a_rx_rd[n]),
        .wdata (b_wdata),
        .data  (ba_data[n]),
        .full  (ba_occ[n])
      );
    end
  endgenerate

  mbox_port #(.CH(CH), .DW(DW), .AW(AW), .HAS_CLR(1'b1)) u_pa (
    .clk      (clk),
    .rst_n    (rst_s),
    .clr      (unit_clr),
    .req      (a_req),
    .we       (a_we),
    .addr     (a_addr),
    .wdata    (a_wdata),
    .rdata    (a_rdata),
    .err      (a_err),
    .irq      (a_irq),
    .tx_empty (~ab_occ),
    .rx_full  (ba_occ),
    .rx_data  (ba_data),
    .tx_wr    (a_tx_wr),
    .rx_rd    (a_rx_rd),
    .clr_req  (a_clr_req)
  );

  mbox_port #(.CH(CH), .DW(DW), .AW(AW), .HAS_CLR(1'b0)) u_pb (
    .clk      (clk),
    .rst_n    (rst_s),
    .clr      (unit_clr),
    .req      (b_req),
    .we       (b_we),
    .addr     (b_addr),
    .wdata    (b_wdata),
    .rdata    (b_rdata),
    .err      (b_err),
    .irq      (b_irq),
    .tx_empty (~ba_occ),
    .rx_full  (ab_occ),
    .rx_data  (ab_data),
    .tx_wr    (b_tx_wr),
    .rx_rd    (b_rx_rd),
    .clr_req  (b_clr_req)
  );
endmodule

// File: rtl/mbox_chk.sv
`timescale 1ns/1ps
module mbox_chk #(
  parameter int unsigned CH = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4
) (
  input logic                  clk,
  input logic                  rst_s,
  input logic                  unit_clr,
  input logic                  a_req,
  input logic                  a_we,
  input logic [AW-1:0]         a_addr,
  input logic [DW-1:0]         a_wdata,
  input logic [DW-1:0]         a_rdata,
  input logic                  a_err,
  input logic                  a_irq,
  input logic                  b_req,
  input logic                  b_we,
  input logic [AW-1:0]         b_addr,
  input logic [DW-1:0]         b_wdata,
  input logic                  b_irq,
  input logic [CH-1:0]         ab_occ,
  input logic [CH-1:0]         ba_occ,
  input logic [CH-1:0][DW-1:0] ab_data,
  input logic [CH-1:0][DW-1:0] ba_data
);
  generate
    for (genvar n = 0; n < CH; n++) begin : g_n
      AST_TX_FILLS_PEER_A: assert property (@(posedge clk) disable iff (!rst_s)
        a_req && a_we && a_addr == AW'(n) && !a_err && !unit_clr
        |=> ab_occ[n] && ab_data[n] == $past(a_wdata)); // R2
      AST_TX_FILLS_PEER_B: assert property (@(posedge clk) disable iff (!rst_s)
        b_req && b_we && b_addr == AW'(n) && !unit_clr && !ba_occ[n]
        |=> ba_occ[n] && ba_data[n] == $past(b_wdata)); // R2
      AST_RX_DRAINS: assert property (@(posedge clk) disable iff (!rst_s)
        b_req && !b_we && b_addr == AW'(CH + n) && !unit_clr
        && !(a_req && a_we && a_addr == AW'(n))
        |=> !ab_occ[n]); // R3
      AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_s)
        a_req && a_we && a_addr == AW'(n) && ab_occ[n] |-> a_err); // R4
      AST_BUSY_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_s)
        a_req && a_we && a_addr == AW'(n) && ab_occ[n] && !unit_clr
        |=> $stable(ab_data[n])); // R4
    end
  endgenerate

  AST_RX_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_s)
    a_req && a_we && a_addr >= AW'(CH) && a_addr < AW'(2 * CH) |-> a_err); // R5
  AST_TX_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
    a_req && !a_we && a_addr < AW'(CH) |-> a_rdata == '0 && !a_err); // R6
  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_s)
    a_irq |-> (|ba_occ) || !(&ab_occ)); // R7
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    unit_clr |=> !a_irq && !b_irq && ab_occ == '0 && ba_occ == '0); // R8
  AST_CLR_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
    a_req && !a_we && a_addr == AW'(2 * CH + 1) |-> !a_rdata[0]); // R8
endmodule

bind dual_mailbox mbox_chk #(.CH(CH), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/sim_dual_mailbox.sv
`timescale 1ns/1ps
module sim_dual_mailbox;
  logic        clk;
  logic        rst_n;
  logic        a_req, a_we, b_req, b_we;
  logic [3:0]  a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic        a_err, a_irq, b_err, b_irq;

  int total = 0;
  int bad   = 0;

  typedef struct {
    bit          side;   // 0 = A, 1 = B
    bit          is_irq;
    bit          chk_rd;
    logic [31:0] rd;
    bit          err;
    bit          irq;
    string       tag;
  } exp_t;

  exp_t q[$];

  dual_mailbox u0 (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_err(a_err), .a_irq(a_irq),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_err(b_err), .b_irq(b_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Monitor: compares each expected item a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        logic [31:0] rd;
        logic        er, iq;
        e  = q.pop_front();
        rd = e.side ? b_rdata : a_rdata;
        er = e.side ? b_err   : a_err;
        iq = e.side ? b_irq   : a_irq;
        if (e.is_irq) begin
          total++;
          if (iq !== e.irq) begin
            bad++;
            $display("FAIL %s: irq=%0b expected %0b", e.tag, iq, e.irq);
          end
        end else begin
          total++;
          if (er !== e.err) begin
            bad++;
            $display("FAIL %s: err=%0b expected %0b", e.tag, er, e.err);
          end
          if (e.chk_rd) begin
            total++;
            if (rd !== e.rd) begin
              bad++;
              $display("FAIL %s: rdata=%08h expected %08h", e.tag, rd, e.rd);
            end
          end
        end
      end
    end
  end

  task automatic bus(input bit side, input bit we, input logic [3:0] addr,
                     input logic [31:0] wd, input bit chk_rd,
                     input logic [31:0] exp_rd, input bit exp_err, input string tag);
    exp_t e;
    @(negedge clk);
    if (!side) begin
      a_req = 1'b1; a_we = we; a_addr = addr; a_wdata = wd;
    end else begin
      b_req = 1'b1; b_we = we; b_addr = addr; b_wdata = wd;
    end
    e.side = side; e.is_irq = 1'b0; e.chk_rd = chk_rd; e.rd = exp_rd;
    e.err = exp_err; e.irq = 1'b0; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1;
    a_req = 1'b0; b_req = 1'b0;
  endtask

  task automatic irqchk(input bit side, input bit exp, input string tag);
    exp_t e;
    @(negedge clk);
    e.side = side; e.is_irq = 1'b1; e.chk_rd = 1'b0; e.rd = '0;
    e.err = 1'b0; e.irq = exp; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, got hang expected completion");
    finish_run();
  end

  initial begin
    a_req = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_req = 0; b_we = 0; b_addr = '0; b_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    bus(0, 0, 4'd8, '0, 1, 32'h00F0_0000, 0, "R1 A status");
    bus(1, 0, 4'd8, '0, 1, 32'h00F0_0000, 0, "R1 B status");
    bus(0, 0, 4'd9, '0, 1, 32'h0, 0, "R1 A control");
    bus(1, 0, 4'd5, '0, 1, 32'h0, 0, "R1 B rx1 data");
    irqchk(0, 0, "R1 A irq");
    irqchk(1, 0, "R1 B irq");

    // R2 / R4 transfer A->B channel 0
    bus(0, 1, 4'd0, 32'hDEAD_BEEF, 0, '0, 0, "R2 A tx0 write");
    bus(1, 0, 4'd8, '0, 1, 32'h01F0_0000, 0, "R2 B full0 set");
    bus(0, 0, 4'd8, '0, 1, 32'h00E0_0000, 0, "R4 A empty0 cleared");
    bus(1, 0, 4'd4, '0, 1, 32'hDEAD_BEEF, 0, "R2 B rx0 data");
    // R3 drain
    bus(1, 0, 4'd8, '0, 1, 32'h00F0_0000, 0, "R3 B full0 cleared");
    bus(0, 0, 4'd8, '0, 1, 32'h00F0_0000, 0, "R3 A empty0 set");
    // R6
    bus(0, 0, 4'd0, '0, 1, 32'h0, 0, "R6 A tx0 reads zero");

    // R4 write to a busy slot is dropped
    bus(0, 1, 4'd1, 32'h0000_1111, 0, '0, 0, "R4 A tx1 first write");
    bus(0, 1, 4'd1, 32'h0000_2222, 0, '0, 1, "R4 A tx1 busy write err");
    bus(1, 0, 4'd5, '0, 1, 32'h0000_1111, 0, "R4 B rx1 keeps first word");

    // R5 errors
    bus(1, 1, 4'd4, 32'hFFFF_FFFF, 0, '0, 1, "R5 B write rx0 err");
    bus(0, 0, 4'd4, '0, 1, 32'h0, 0, "R5 A rx0 untouched");
    bus(0, 0, 4'd12, '0, 1, 32'h0, 1, "R5 A unmapped read");
    bus(0, 1, 4'd10, 32'h1, 0, '0, 1, "R5 A unmapped write");
    // R9 status write ignored
    bus(0, 1, 4'd8, 32'hFFFF_FFFF, 0, '0, 0, "R9 A status write no err");
    bus(0, 0, 4'd8, '0, 1, 32'h00F0_0000, 0, "R9 A status unchanged");

    // B->A channel 3
    bus(1, 1, 4'd3, 32'hCAFE_0003, 0, '0, 0, "R2 B tx3 write");
    bus(0, 0, 4'd8, '0, 1, 32'h08F0_0000, 0, "R2 A full3 set");
    bus(1, 0, 4'd8, '0, 1, 32'h0070_0000, 0, "R4 B empty3 cleared");

    // R7 receive interrupt
    irqchk(0, 0, "R7 A irq before enable");
    bus(0, 1, 4'd9, 32'h0800_0000, 0, '0, 0, "R7 A enable rx3 irq");
    irqchk(0, 1, "R7 A irq on full3");
    bus(0, 0, 4'd9, '0, 1, 32'h0800_0000, 0, "R7 A control readback");
    bus(0, 0, 4'd7, '0, 1, 32'hCAFE_0003, 0, "R2 A rx3 data");
    irqchk(0, 0, "R7 A irq after drain");

    // R7 transmit interrupt on B
    bus(1, 1, 4'd9, 32'h0040_0000, 0, '0, 0, "R7 B enable tx2 irq");
    irqchk(1, 1, "R7 B irq empty2");
    bus(1, 1, 4'd2, 32'h0000_00B2, 0, '0, 0, "R7 B tx2 write");
    irqchk(1, 0, "R7 B irq after tx2 write");
    bus(0, 0, 4'd6, '0, 1, 32'h0000_00B2, 0, "R3 A rx2 data");
    irqchk(1, 1, "R7 B irq after peer drain");

    // R8 unit clear
    bus(0, 1, 4'd0, 32'h0000_0055, 0, '0, 0, "R8 A tx0 before clear");
    bus(1, 1, 4'd9, 32'h0040_0001, 0, '0, 0, "R8 B bit0 write");
    bus(1, 0, 4'd9, '0, 1, 32'h0040_0000, 0, "R8 B bit0 no effect");
    bus(1, 0, 4'd8, '0, 1, 32'h01F0_0000, 0, "R8 B state kept");
    bus(0, 1, 4'd9, 32'h0000_0001, 0, '0, 0, "R8 A clear write");
    bus(1, 0, 4'd8, '0, 1, 32'h00F0_0000, 0, "R8 B status default");
    bus(0, 0, 4'd8, '0, 1, 32'h00F0_0000, 0, "R8 A status default");
    bus(0, 0, 4'd9, '0, 1, 32'h0, 0, "R8 A control reads zero");
    bus(1, 0, 4'd9, '0, 1, 32'h0, 0, "R8 B control cleared");
    bus(1, 0, 4'd4, '0, 1, 32'h0, 0, "R8 B rx0 data cleared");
    irqchk(1, 0, "R8 B irq low");

    repeat (3) @(posedge clk);
    #1;
    finish_run();
  end
endmodule